// File: doc/BRIEF.md
# Rename Table Checkpoint Unit

This block holds the live register-rename table of an out-of-order core and checkpoints it for hardware transactions. Dispatch logic writes rename updates into the live table. When the first transaction-begin command arrives with no transaction open, the block takes one snapshot of the mapping and stores the abort-handler address. In the same step it marks a saved bit for every physical register that the snapshot references. Begin commands that arrive while a transaction is already open only raise the nesting depth.

If an abort arrives while a transaction is open, the live table is restored from the snapshot and the saved bits are cleared. For exactly one cycle the block then presents a fetch redirect carrying the stored handler address. An end at depth one commits the transaction and releases the snapshot. Physical registers that dispatch offers for reclamation are passed on as free only when their saved bit is clear, so the checkpointed mapping stays intact for as long as a rollback is possible.

Top module: `rckpt_unit`

## Requirements
- R1: After reset the table maps architectural register i to physical register i, depth is 0, `active_o`, `redirect_o` and `end_err_o` are low, `redirect_pc_o` is 0 and `free_o` equals `release_i`.
- R2: A rename update (`ren_we_i`) writes `ren_phys_i` into the entry `ren_arch_i`. The new value is visible on `lookup_phys_o` from the cycle after the edge. The update happens in every cycle without an abort that is accepted.
- R3: A begin with depth 0 snapshots the table as it was before that cycle's rename update, stores `begin_pc_i` as the handler and sets depth to 1. It also sets a saved bit for each physical register referenced by the snapshot. While the transaction is active, `free_o` = `release_i` with every saved bit masked off.
- R4: A begin while active increments depth by one, saturating at 2^DEPTH_W-1. It takes no new snapshot and keeps the stored handler.
- R5: An end at depth greater than 1 decrements depth by one.
- R6: An end at depth 1 sets depth to 0 and clears all saved bits. The live table keeps its current mapping.
- R7: An end with depth 0 changes no state and pulses `end_err_o` high for one cycle after the edge.
- R8: An abort while active restores the whole table to the snapshot, sets depth to 0 and clears all saved bits. In the next cycle only, `redirect_o` is high and `redirect_pc_o` holds the handler. `redirect_pc_o` is 0 whenever `redirect_o` is low.
- R9: An abort that is accepted overrides a begin, an end and a rename update in the same cycle. None of them takes effect.
- R10: An abort with depth 0 is ignored: there is no redirect, and other commands and the rename update of that cycle proceed normally.
- R11: A begin and an end in the same cycle act as the begin alone. The end is dropped and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Transaction begin command |
| begin_pc_i | input | PC_W | Abort-handler address carried by begin |
| end_i | input | 1 | Transaction end command |
| abort_i | input | 1 | Abort request |
| ren_we_i | input | 1 | Rename update strobe |
| ren_arch_i | input | $clog2(ARCH_REGS) | Architectural register being renamed |
| ren_phys_i | input | $clog2(PHYS_REGS) | New physical register for it |
| lookup_arch_i | input | $clog2(ARCH_REGS) | Table read index |
| lookup_phys_o | output | $clog2(PHYS_REGS) | Live mapping of `lookup_arch_i` |
| release_i | input | PHYS_REGS | Registers offered for reclamation |
| free_o | output | PHYS_REGS | Offered registers that may really be reclaimed |
| active_o | output | 1 | Transaction open |
| depth_o | output | DEPTH_W | Nesting depth |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | PC_W | Redirect target |
| end_err_o | output | 1 | End without a transaction |

## Verification
The bench builds the block with 16 architectural registers, 32 physical registers and a 32-bit address, but with DEPTH_W set to 2. The depth therefore saturates at 3, and random begin commands reach that limit often. Saturation and the abort that follows it are then exercised in many cycles rather than in a single hand-built case. Full-table sweeps after every edge show whether a nested begin has overwritten the snapshot.

// File: rtl/rckpt_pkg.sv
`timescale 1ns/1ps
package rckpt_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ABORT = 2'd1,
    OP_BEGIN = 2'd2,
    OP_END   = 2'd3
  } txn_op_e;
endpackage

// File: rtl/rckpt_txn_ctrl.sv
`timescale 1ns/1ps
module rckpt_txn_ctrl
  import rckpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DEPTH_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic [PC_W-1:0]    begin_pc_i,
  input  logic               end_i,
  input  logic               abort_i,
  output logic               snap_o,
  output logic               restore_o,
  output logic               clear_saved_o,
  output logic               active_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               end_err_o
);
  localparam logic [DEPTH_W-1:0] DMax = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] DOne = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q;
  logic [PC_W-1:0]    handler_q;
  logic               redirect_q, err_q;
  logic [PC_W-1:0]    redirect_pc_q;
  txn_op_e            op;
  logic               active;

  assign active = (depth_q != '0);

  // abort > begin > end
  always_comb begin
    if (abort_i && active)  op = OP_ABORT;
    else if (begin_i)       op = OP_BEGIN;
    else if (end_i)         op = OP_END;
    else                    op = OP_NONE;
  end

  assign snap_o        = (op == OP_BEGIN) && !active;
  assign restore_o     = (op == OP_ABORT);
  assign clear_saved_o = restore_o || ((op == OP_END) && (depth_q == DOne));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q       <= '0;
      handler_q     <= '0;
      redirect_q    <= 1'b0;
      redirect_pc_q <= '0;
      err_q         <= 1'b0;
    end else begin
      redirect_q    <= 1'b0;
      redirect_pc_q <= '0;
      err_q         <= 1'b0;
      unique case (op)
        OP_ABORT: begin
          depth_q       <= '0;
          redirect_q    <= 1'b1;
          redirect_pc_q <= handler_q;
        end
        OP_BEGIN: begin
          if (!active) begin
            depth_q   <= DOne;
            handler_q <= begin_pc_i;
          end else if (depth_q != DMax) begin
            depth_q <= depth_q + DOne;
          end
        end
        OP_END: begin
          if (!active) err_q   <= 1'b1;
          else         depth_q <= depth_q - DOne;
        end
        default: ;
      endcase
    end
  end

  assign active_o      = active;
  assign depth_o       = depth_q;
  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redirect_pc_q;
  assign end_err_o     = err_q;
endmodule

// File: rtl/rckpt_map_table.sv
`timescale 1ns/1ps
module rckpt_map_table #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 32,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          arch_i,
  input  logic [PW-1:0]          phys_i,
  input  logic                   snap_i,
  input  logic                   restore_i,
  input  logic [AW-1:0]          lookup_arch_i,
  output logic [PW-1:0]          lookup_phys_o,
  output logic [ARCH_REGS*PW-1:0] live_flat_o
);
  logic [PW-1:0] live_q [ARCH_REGS];
  logic [PW-1:0] snap_q [ARCH_REGS];

  for (genvar a = 0; a < ARCH_REGS; a++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[a] <= PW'(a);
        snap_q[a] <= PW'(a);
      end else begin
        if (restore_i)                        live_q[a] <= snap_q[a];
        else if (we_i && (arch_i == AW'(a)))  live_q[a] <= phys_i;
        if (snap_i)                           snap_q[a] <= live_q[a];
      end
    end
    assign live_flat_o[a*PW +: PW] = live_q[a];
  end

  assign lookup_phys_o = live_q[lookup_arch_i];
endmodule

// File: rtl/rckpt_saved_mask.sv
`timescale 1ns/1ps
module rckpt_saved_mask #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 32,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ARCH_REGS*PW-1:0] live_flat_i,
  input  logic                    snap_i,
  input  logic                    clear_i,
  output logic [PHYS_REGS-1:0]    saved_o
);
  logic [PHYS_REGS-1:0] hit;
  logic [PHYS_REGS-1:0] saved_q;

  for (genvar p = 0; p < PHYS_REGS; p++) begin : g_phys
    always_comb begin
      hit[p] = 1'b0;
      for (int a = 0; a < ARCH_REGS; a++) begin
        if (live_flat_i[a*PW +: PW] == PW'(p)) hit[p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      saved_q <= '0;
    else if (clear_i) saved_q <= '0;
    else if (snap_i)  saved_q <= hit;
  end

  assign saved_o = saved_q;
endmodule

// File: rtl/rckpt_unit.sv
`timescale 1ns/1ps
module rckpt_unit #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 32,
  parameter int PC_W      = 32,
  parameter int DEPTH_W   = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 begin_i,
  input  logic [PC_W-1:0]      begin_pc_i,
  input  logic                 end_i,
  input  logic                 abort_i,
  input  logic                 ren_we_i,
  input  logic [AW-1:0]        ren_arch_i,
  input  logic [PW-1:0]        ren_phys_i,
  input  logic [AW-1:0]        lookup_arch_i,
  output logic [PW-1:0]        lookup_phys_o,
  input  logic [PHYS_REGS-1:0] release_i,
  output logic [PHYS_REGS-1:0] free_o,
  output logic                 active_o,
  output logic [DEPTH_W-1:0]   depth_o,
  output logic                 redirect_o,
  output logic [PC_W-1:0]      redirect_pc_o,
  output logic                 end_err_o
);
  logic                    snap, restore, clear_saved;
  logic [ARCH_REGS*PW-1:0] live_flat;
  logic [PHYS_REGS-1:0]    saved;

  rckpt_txn_ctrl #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk_i, .rst_ni, .begin_i, .begin_pc_i, .end_i, .abort_i,
    .snap_o(snap), .restore_o(restore), .clear_saved_o(clear_saved),
    .active_o, .depth_o, .redirect_o, .redirect_pc_o, .end_err_o
  );

  rckpt_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_table (
    .clk_i, .rst_ni, .we_i(ren_we_i), .arch_i(ren_arch_i), .phys_i(ren_phys_i),
    .snap_i(snap), .restore_i(restore), .lookup_arch_i, .lookup_phys_o,
    .live_flat_o(live_flat)
  );

  rckpt_saved_mask #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_saved (
    .clk_i, .rst_ni, .live_flat_i(live_flat), .snap_i(snap),
    .clear_i(clear_saved), .saved_o(saved)
  );

  assign free_o = release_i & ~saved;
endmodule

// File: rtl/rckpt_checker.sv
`timescale 1ns/1ps
module rckpt_checker #(
  parameter int PHYS_REGS = 32,
  parameter int DEPTH_W   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 begin_i,
  input logic                 end_i,
  input logic                 abort_i,
  input logic [PHYS_REGS-1:0] release_i,
  input logic [PHYS_REGS-1:0] free_o,
  input logic                 active_o,
  input logic [DEPTH_W-1:0]   depth_o,
  input logic                 redirect_o,
  input logic                 end_err_o
);
  localparam logic [DEPTH_W-1:0] DMax = {DEPTH_W{1'b1}};

  p_redirect_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  p_abort_unwind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && abort_i) |=> (redirect_o && !active_o && depth_o == '0));

  p_idle_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> !redirect_o);

  p_nest_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && begin_i && !abort_i && depth_o != DMax)
      |=> depth_o == $past(depth_o) + DEPTH_W'(1));

  p_stray_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && end_i && !begin_i) |=> end_err_o);

  p_free_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (free_o == release_i));
endmodule

bind rckpt_unit rckpt_checker #(.PHYS_REGS(PHYS_REGS), .DEPTH_W(DEPTH_W)) u_chk (
  .clk_i, .rst_ni, .begin_i, .end_i, .abort_i, .release_i, .free_o,
  .active_o, .depth_o, .redirect_o, .end_err_o
);

// File: tb/rckpt_unit_tb_top.sv
`timescale 1ns/1ps
module rckpt_unit_tb_top;
  localparam int NA = 16, NP = 32, PCW = 32, DW = 2;
  localparam int AW = $clog2(NA), PW = $clog2(NP);
  localparam int DMAX = (1 << DW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic begin_i = 0, end_i = 0, abort_i = 0, ren_we_i = 0;
  logic [PCW-1:0] begin_pc_i = '0;
  logic [AW-1:0] ren_arch_i = '0, lookup_arch_i = '0;
  logic [PW-1:0] ren_phys_i = '0, lookup_phys_o;
  logic [NP-1:0] release_i = '0, free_o;
  logic active_o, redirect_o, end_err_o;
  logic [DW-1:0] depth_o;
  logic [PCW-1:0] redirect_pc_o;

  rckpt_unit #(.ARCH_REGS(NA), .PHYS_REGS(NP), .PC_W(PCW), .DEPTH_W(DW)) dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [PW-1:0] m_tab [NA];
  logic [PW-1:0] m_snap [NA];
  logic [NP-1:0] m_saved;
  logic [PCW-1:0] m_handler;
  int m_depth;
  logic e_redir, e_err;
  logic [PCW-1:0] e_pc;
  string tag;

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] refs_of_table();
    logic [NP-1:0] r = '0;
    for (int a = 0; a < NA; a++) r[m_tab[a]] = 1'b1;
    return r;
  endfunction

  // model step: state before edge + current inputs -> state after edge
  task automatic model_step();
    logic hit = abort_i && (m_depth > 0);
    e_redir = hit; e_pc = hit ? m_handler : '0; e_err = 1'b0;
    if (hit) tag = (begin_i || end_i || ren_we_i) ? "R9" : "R8";
    else if (abort_i) tag = "R10";
    else if (begin_i && end_i) tag = "R11";
    else if (begin_i) tag = (m_depth == 0) ? "R3" : "R4";
    else if (end_i) tag = (m_depth == 0) ? "R7" : (m_depth == 1) ? "R6" : "R5";
    else tag = "R2";
    if (hit) begin
      for (int a = 0; a < NA; a++) m_tab[a] = m_snap[a];
      m_saved = '0; m_depth = 0;
    end else begin
      if (begin_i) begin
        if (m_depth == 0) begin
          m_saved = refs_of_table();
          for (int a = 0; a < NA; a++) m_snap[a] = m_tab[a];
          m_handler = begin_pc_i; m_depth = 1;
        end else if (m_depth < DMAX) m_depth++;
      end else if (end_i) begin
        if (m_depth == 0) e_err = 1'b1;
        else begin
          m_depth--;
          if (m_depth == 0) m_saved = '0;
        end
      end
      if (ren_we_i) m_tab[ren_arch_i] = ren_phys_i;
    end
  endtask

  task automatic check_outputs(input string t);
    logic bad = 1'b0;
    chk(t, "depth_o", depth_o, m_depth);
    chk(t, "active_o", active_o, m_depth != 0);
    chk(t, "redirect_o", redirect_o, e_redir);
    chk(t, "redirect_pc_o", redirect_pc_o, e_pc);
    chk(t, "end_err_o", end_err_o, e_err);
    chk("R3", "free_o", free_o, release_i & ~m_saved);
    for (int a = 0; a < NA; a++) begin
      lookup_arch_i = AW'(a);
      #0.1;
      if (!bad && lookup_phys_o !== m_tab[a]) begin
        bad = 1'b1;
        chk(t, $sformatf("table[%0d]", a), lookup_phys_o, m_tab[a]);
      end
    end
    if (!bad) checks++;
  endtask

  task automatic step(input logic b, input logic [PCW-1:0] pc, input logic e, input logic ab,
                      input logic we, input logic [AW-1:0] ar, input logic [PW-1:0] ph,
                      input logic [NP-1:0] rel);
    @(negedge clk_i);
    begin_i = b; begin_pc_i = pc; end_i = e; abort_i = ab;
    ren_we_i = we; ren_arch_i = ar; ren_phys_i = ph; release_i = rel;
    model_step();
    @(posedge clk_i);
    #0.5;
    check_outputs(tag);
  endtask

  logic done = 1'b0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int a = 0; a < NA; a++) begin m_tab[a] = PW'(a); m_snap[a] = PW'(a); end
    m_saved = '0; m_handler = '0; m_depth = 0;
    e_redir = 0; e_err = 0; e_pc = '0;
    release_i = 32'hdead_beef;
    repeat (3) @(negedge clk_i);
    check_outputs("R1");
    rst_ni = 1'b1;
    // directed corners
    step(0, 0, 1, 0, 0, 0, 0, '1);                 // R7 stray end
    step(0, 0, 0, 1, 1, 4'd3, 5'd20, '1);          // R10 idle abort, rename proceeds
    step(1, 32'h1000, 0, 0, 1, 4'd3, 5'd21, '1);   // R3 outer begin, snapshot pre-update
    step(1, 32'h2000, 0, 0, 1, 4'd4, 5'd22, '1);   // R4 nested
    step(1, 32'h3000, 0, 0, 0, 0, 0, '1);          // R4
    step(1, 32'h4000, 0, 0, 0, 0, 0, '1);          // R4 saturation
    step(0, 0, 1, 0, 0, 0, 0, '1);                 // R5
    step(1, 32'h5000, 1, 0, 0, 0, 0, '1);          // R11
    step(1, 32'h6000, 1, 1, 1, 4'd5, 5'd30, '1);   // R9 abort wins
    step(0, 0, 0, 0, 0, 0, 0, '1);
    step(1, 32'h7000, 0, 0, 1, 4'd0, 5'd31, '1);   // R3
    step(0, 0, 1, 0, 0, 0, 0, '1);                 // R6 commit
    step(0, 0, 0, 1, 0, 0, 0, '1);                 // R10
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 5) == 0, $urandom, ($urandom % 5) == 0, ($urandom % 12) == 0,
           $urandom[0], AW'($urandom), PW'($urandom), $urandom);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule